// File: doc/BRIEF.md
# Long-Word Write Bus Master

This block is a synchronous master for a processor-style external bus that performs only 32-bit long-word write transfers. A local requester presents an address, write data, a noncacheable flag, an alternate-space flag, a transfer type code, a transfer modifier code and two user page attribute bits, using a valid/ready handshake. Address translation is assumed to be complete, so the page attribute bits arrive with the request.

Each accepted request runs as an address phase of one clock, then a data phase. The data phase lasts until the slave returns an active-low acknowledge, and every clock without acknowledge adds one wait state. While a transfer runs, the block drives the address, the attributes, the size code, the read/write line, a one-clock transfer-start strobe, a transfer-in-progress line, a cache-inhibit line and the write data. If another request is waiting when the acknowledge arrives, the next address phase begins on the following clock and transfer-in-progress does not drop between the two transfers.

Top module: `lwbus_wr_master`

## Requirements
- R1: After reset, `bus_start_n`, `bus_inprog_n`, `bus_rw` and `bus_cinh_n` are 1, `bus_data_oe` is 0 and `req_ready` is 1.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both 1) gives the address phase after that edge. In the address phase `bus_start_n` is 0. It is 0 for exactly that one clock.
- R3: From the address phase until the acknowledge edge, `bus_addr`, `bus_ttype`, `bus_tmod` and `bus_upa` hold the values that were captured with the request.
- R4: `bus_size` is 2'b00 (long-word) throughout a transfer.
- R5: `bus_rw` is 0 from the address phase through the clock in which the acknowledge is sampled. It is 1 when the bus is idle.
- R6: During a transfer `bus_cinh_n` is 0 when the request had the noncacheable flag or the alternate-space flag set. It is 1 when neither flag was set.
- R7: `bus_data_oe` is 1 and `bus_data` carries the request's write data from the clock after the address phase until an edge at which `bus_ack_n` is 0. Each clock with `bus_ack_n` at 1 adds one wait state and leaves `bus_data` unchanged.
- R8: `bus_inprog_n` goes to 0 in the address phase. If no request is accepted at the acknowledge edge, it returns to 1 on the clock after that edge.
- R9: If a request is accepted at the acknowledge edge, a new address phase follows at once and `bus_inprog_n` stays 0.
- R10: `req_ready` is 1 when the bus is idle and in a data-phase clock in which `bus_ack_n` is 0. It is 0 otherwise.
- R11: `bus_ack_n` at 0 has no effect outside the data phase. While idle, the bus stays idle. During the address phase, the data phase still follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all changes follow its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The block accepts a request at this edge |
| req_addr | input | 32 | Byte address of the write |
| req_data | input | 32 | Long-word write data |
| req_nocache | input | 1 | Access is noncacheable |
| req_altspace | input | 1 | Access targets an alternate address space |
| req_ttype | input | 2 | Transfer type code |
| req_tmod | input | 3 | Transfer modifier code |
| req_upa | input | 2 | User page attribute bits of the accessed area |
| bus_addr | output | 32 | Address lines |
| bus_data | output | 32 | Write data lines |
| bus_data_oe | output | 1 | Data lines are driven |
| bus_ttype | output | 2 | Transfer type |
| bus_tmod | output | 3 | Transfer modifier |
| bus_upa | output | 2 | User page attributes |
| bus_size | output | 2 | Transfer size, 00 for long-word |
| bus_rw | output | 1 | Read/write, 0 for a write |
| bus_start_n | output | 1 | Transfer start strobe, active low |
| bus_inprog_n | output | 1 | Transfer in progress, active low |
| bus_cinh_n | output | 1 | Cache inhibit, active low |
| bus_ack_n | input | 1 | Transfer acknowledge from the slave, active low |

## Verification
All bus outputs are registered. The address-phase values appear one clock after the accepting edge, and the data phase starts two clocks after it. Leaving the data phase takes one clock after the edge at which the acknowledge is sampled. `req_ready` is the only combinational output and responds to `bus_ack_n` within the same clock. The bench changes inputs and samples outputs on the falling edge. It therefore reads each registered result half a clock after the rising edge that produced it, and reads `req_ready` after the acknowledge has settled and before the edge that consumes it.

// File: rtl/lwbus_pkg.sv
package lwbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam int SIZE_W = 2;
    localparam logic [SIZE_W-1:0] SIZE_LONG = 2'b00;

endpackage

// File: rtl/lwbus_attr_enc.sv
module lwbus_attr_enc
    import lwbus_pkg::*;
(
    input  logic              nocache,
    input  logic              altspace,
    output logic              cinh_n,
    output logic [SIZE_W-1:0] size
);

    // Cache inhibit covers both uncached areas and alternate-space accesses.
    always_comb begin
        cinh_n = ~(nocache | altspace);
        size   = SIZE_LONG;
    end

endmodule

// File: rtl/lwbus_wr_master.sv
module lwbus_wr_master
    import lwbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TT_W   = 2,
    parameter int TM_W   = 3,
    parameter int UPA_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_nocache,
    input  logic              req_altspace,
    input  logic [TT_W-1:0]   req_ttype,
    input  logic [TM_W-1:0]   req_tmod,
    input  logic [UPA_W-1:0]  req_upa,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic [TT_W-1:0]   bus_ttype,
    output logic [TM_W-1:0]   bus_tmod,
    output logic [UPA_W-1:0]  bus_upa,
    output logic [SIZE_W-1:0] bus_size,
    output logic              bus_rw,
    output logic              bus_start_n,
    output logic              bus_inprog_n,
    output logic              bus_cinh_n,
    input  logic              bus_ack_n
);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TT_W-1:0]   ttype;
        logic [TM_W-1:0]   tmod;
        logic [UPA_W-1:0]  upa;
        logic [SIZE_W-1:0] size;
        logic              data_oe;
        logic              rw;
        logic              start_n;
        logic              inprog_n;
        logic              cinh_n;
    } bus_state_t;

    localparam bus_state_t RESET_STATE = '{
        ph:       PH_IDLE,
        addr:     '0,
        data:     '0,
        ttype:    '0,
        tmod:     '0,
        upa:      '0,
        size:     SIZE_LONG,
        data_oe:  1'b0,
        rw:       1'b1,
        start_n:  1'b1,
        inprog_n: 1'b1,
        cinh_n:   1'b1
    };

    bus_state_t        st_d, st_q;
    logic              enc_cinh_n;
    logic [SIZE_W-1:0] enc_size;
    logic              take;

    lwbus_attr_enc i_attr_enc (
        .nocache  (req_nocache),
        .altspace (req_altspace),
        .cinh_n   (enc_cinh_n),
        .size     (enc_size)
    );

    always_comb begin
        st_d      = st_q;
        req_ready = (st_q.ph == PH_IDLE) || ((st_q.ph == PH_DATA) && !bus_ack_n);
        take      = req_valid && req_ready;

        unique case (st_q.ph)
            PH_ADDR: begin
                // Acknowledge is not looked at in the address phase.
                st_d.ph      = PH_DATA;
                st_d.start_n = 1'b1;
                st_d.data_oe = 1'b1;
            end
            PH_DATA: begin
                if (!bus_ack_n) begin
                    st_d.ph       = PH_IDLE;
                    st_d.data_oe  = 1'b0;
                    st_d.rw       = 1'b1;
                    st_d.inprog_n = 1'b1;
                    st_d.cinh_n   = 1'b1;
                end
            end
            default: begin
            end
        endcase

        if (take) begin
            st_d.ph       = PH_ADDR;
            st_d.addr     = req_addr;
            st_d.data     = req_data;
            st_d.ttype    = req_ttype;
            st_d.tmod     = req_tmod;
            st_d.upa      = req_upa;
            st_d.size     = enc_size;
            st_d.cinh_n   = enc_cinh_n;
            st_d.data_oe  = 1'b0;
            st_d.rw       = 1'b0;
            st_d.start_n  = 1'b0;
            st_d.inprog_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign bus_addr     = st_q.addr;
    assign bus_data     = st_q.data;
    assign bus_data_oe  = st_q.data_oe;
    assign bus_ttype    = st_q.ttype;
    assign bus_tmod     = st_q.tmod;
    assign bus_upa      = st_q.upa;
    assign bus_size     = st_q.size;
    assign bus_rw       = st_q.rw;
    assign bus_start_n  = st_q.start_n;
    assign bus_inprog_n = st_q.inprog_n;
    assign bus_cinh_n   = st_q.cinh_n;

    AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_start_n |=> bus_start_n); // R2

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !bus_start_n); // R2

    AST_ATTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_ack_n)) |-> ($stable(bus_addr) && $stable(bus_ttype)
            && $stable(bus_tmod) && $stable(bus_upa))); // R3

    AST_SIZE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_inprog_n |-> (bus_size == 2'b00)); // R4

    AST_RW_LOW_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_start_n || bus_data_oe) |-> !bus_rw); // R5

    AST_CINH_FROM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_cinh_n == !($past(req_nocache) || $past(req_altspace)))); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_data_oe) && $past(bus_ack_n)) |-> $stable(bus_data)); // R7

    AST_INPROG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && !bus_ack_n && !req_valid) |=> bus_inprog_n); // R8

    AST_INPROG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && !bus_ack_n && req_valid) |=> (!bus_inprog_n && !bus_start_n)); // R9

    AST_IDLE_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_inprog_n && !req_valid) |=> (bus_inprog_n && !bus_data_oe)); // R11

endmodule

// File: tb/test_lwbus_wr_master.sv
module test_lwbus_wr_master;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic        nc;
        logic        alt;
        logic [1:0]  tt;
        logic [2:0]  tm;
        logic [1:0]  upa;
        logic [3:0]  waits;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'hDEAD_BEEF, 1'b0, 1'b0, 2'd0, 3'd1, 2'b00, 4'd0},
        '{32'h8000_0004, 32'h1234_5678, 1'b1, 1'b0, 2'd1, 3'd5, 2'b01, 4'd2},
        '{32'hFFFF_FFFC, 32'h0F0F_F0F0, 1'b0, 1'b1, 2'd2, 3'd2, 2'b10, 4'd1},
        '{32'h0000_0008, 32'hA5A5_5A5A, 1'b1, 1'b1, 2'd0, 3'd6, 2'b11, 4'd5},
        '{32'h7654_3210, 32'h0000_0001, 1'b0, 1'b0, 2'd3, 3'd7, 2'b01, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_nocache = 1'b0;
    logic        req_altspace = 1'b0;
    logic [1:0]  req_ttype = '0;
    logic [2:0]  req_tmod = '0;
    logic [1:0]  req_upa = '0;
    logic [31:0] bus_addr;
    logic [31:0] bus_data;
    logic        bus_data_oe;
    logic [1:0]  bus_ttype;
    logic [2:0]  bus_tmod;
    logic [1:0]  bus_upa;
    logic [1:0]  bus_size;
    logic        bus_rw;
    logic        bus_start_n;
    logic        bus_inprog_n;
    logic        bus_cinh_n;
    logic        bus_ack_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lwbus_wr_master i_lwbus_wr_master (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_data,
        .req_nocache, .req_altspace, .req_ttype, .req_tmod, .req_upa,
        .bus_addr, .bus_data, .bus_data_oe, .bus_ttype, .bus_tmod, .bus_upa,
        .bus_size, .bus_rw, .bus_start_n, .bus_inprog_n, .bus_cinh_n, .bus_ack_n
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_req(input vec_t v);
        req_valid    = 1'b1;
        req_addr     = v.addr;
        req_data     = v.data;
        req_nocache  = v.nc;
        req_altspace = v.alt;
        req_ttype    = v.tt;
        req_tmod     = v.tm;
        req_upa      = v.upa;
    endtask

    // Called at a falling edge in the address phase.
    task automatic check_addr_phase(input vec_t v);
        chk("R2 start low", {31'd0, bus_start_n}, 32'd0);
        chk("R8 inprog low", {31'd0, bus_inprog_n}, 32'd0);
        chk("R5 rw low", {31'd0, bus_rw}, 32'd0);
        chk("R3 addr", bus_addr, v.addr);
        chk("R3 ttype/tmod/upa", {25'd0, bus_ttype, bus_tmod, bus_upa},
            {25'd0, v.tt, v.tm, v.upa});
        chk("R4 size", {30'd0, bus_size}, 32'd0);
        chk("R6 cinh", {31'd0, bus_cinh_n}, {31'd0, !(v.nc || v.alt)});
        chk("R10 ready low in addr", {31'd0, req_ready}, 32'd0);
    endtask

    // Called at a falling edge in the data phase.
    task automatic check_data_phase(input vec_t v);
        chk("R7 data_oe", {31'd0, bus_data_oe}, 32'd1);
        chk("R7 data", bus_data, v.data);
        chk("R2 start high", {31'd0, bus_start_n}, 32'd1);
        chk("R5 rw low", {31'd0, bus_rw}, 32'd0);
        chk("R3 addr held", bus_addr, v.addr);
        chk("R6 cinh held", {31'd0, bus_cinh_n}, {31'd0, !(v.nc || v.alt)});
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " R8 inprog high"}, {31'd0, bus_inprog_n}, 32'd1);
        chk({tag, " R5 rw high"}, {31'd0, bus_rw}, 32'd1);
        chk({tag, " R7 data_oe low"}, {31'd0, bus_data_oe}, 32'd0);
        chk({tag, " R10 ready"}, {31'd0, req_ready}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        vec_t b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 start", {31'd0, bus_start_n}, 32'd1);
        chk("R1 inprog", {31'd0, bus_inprog_n}, 32'd1);
        chk("R1 rw", {31'd0, bus_rw}, 32'd1);
        chk("R1 cinh", {31'd0, bus_cinh_n}, 32'd1);
        chk("R1 data_oe", {31'd0, bus_data_oe}, 32'd0);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: isolated transfers with varied wait states
        for (int i = 0; i < NV; i++) begin
            drive_req(VECS[i]);
            chk("R10 ready idle", {31'd0, req_ready}, 32'd1);
            @(negedge clk);
            req_valid = 1'b0;
            check_addr_phase(VECS[i]);
            @(negedge clk);
            for (int w = 0; w < int'(VECS[i].waits); w++) begin
                check_data_phase(VECS[i]);
                chk("R10 ready low in wait", {31'd0, req_ready}, 32'd0);
                @(negedge clk);
            end
            check_data_phase(VECS[i]);
            bus_ack_n = 1'b0;
            #1;
            chk("R10 ready on ack", {31'd0, req_ready}, 32'd1);
            @(negedge clk);
            bus_ack_n = 1'b1;
            check_idle("after ack");
        end

        // R11: acknowledge while idle has no effect
        bus_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R11 idle ack");
        bus_ack_n = 1'b1;

        // R11: acknowledge during the address phase is ignored
        drive_req(VECS[1]);
        @(negedge clk);
        req_valid = 1'b0;
        check_addr_phase(VECS[1]);
        bus_ack_n = 1'b0;
        @(negedge clk);
        bus_ack_n = 1'b1;
        chk("R11 data phase follows", {31'd0, bus_data_oe}, 32'd1);
        chk("R11 still in progress", {31'd0, bus_inprog_n}, 32'd0);
        check_data_phase(VECS[1]);
        bus_ack_n = 1'b0;
        @(negedge clk);
        bus_ack_n = 1'b1;
        check_idle("R11 end");

        // R9: back-to-back transfers keep transfer-in-progress low
        drive_req(VECS[2]);
        @(negedge clk);
        req_valid = 1'b0;
        check_addr_phase(VECS[2]);
        @(negedge clk);
        check_data_phase(VECS[2]);
        b = VECS[3];
        drive_req(b);
        bus_ack_n = 1'b0;
        #1;
        chk("R10 ready with pending", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        bus_ack_n = 1'b1;
        req_valid = 1'b0;
        chk("R9 inprog held", {31'd0, bus_inprog_n}, 32'd0);
        check_addr_phase(b);
        @(negedge clk);
        check_data_phase(b);
        chk("R9 new data", bus_data, b.data);
        bus_ack_n = 1'b0;
        @(negedge clk);
        bus_ack_n = 1'b1;
        check_idle("R9 end");

        // R1 again: reset in the middle of a data phase
        drive_req(VECS[0]);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset inprog", {31'd0, bus_inprog_n}, 32'd1);
        chk("R1 mid reset oe", {31'd0, bus_data_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule